// File: doc/BRIEF.md
# CPU Clock Rate Enable Generator

This block produces the clock enable that paces a CPU core. The core runs on a fast master clock and only advances in cycles where the enable is high. An 8-bit counter runs on the master clock and serves as one power-of-two divider chain. An 8:1 selector picks one of its taps, chosen by a 3-bit speed code. The chosen tap is registered on the master clock, so the output is one master cycle wide and is resynchronised to that clock.

Software changes the rate only by writing a new speed code. The switch is made without glitches. A written code waits until the running period ends, and the counter restarts with it, so every gap between pulses is a whole period of either the old rate or the new rate.

A mode bit says whether the master clock comes from the internal oscillator or from an external source. The code table is the same in both modes. Any change of the mode bit restarts the divider chain, so the first period after the change is a full one.

Top module: `cpu_rate_gen`

## Requirements
- R1: After reset, `cpu_en` is 0 and `code_now` is 000. With no write, the first `cpu_en` pulse comes on the 8th rising edge after reset is released.
- R2: Each speed code sets the gap between `cpu_en` pulses in master cycles: code 0 gives 8, code 1 gives 4, code 2 gives 2, code 3 gives 1, code 4 gives 16, code 5 gives 32, code 6 gives 128 and code 7 gives 256.
- R3: For every code except 011, `cpu_en` is high for exactly one master cycle per period. Code 011 holds `cpu_en` high in every cycle.
- R4: A code written at a rising edge takes effect at the first later edge where the current period ends. `cpu_en` pulses at that edge as the last pulse of the old rate. The next pulse follows exactly one new period later.
- R5: `code_now` shows the code currently in effect. It changes at the same edge as the switch pulse of R4, or at a restart (R8). Until then it keeps the old code.
- R6: A second write that arrives while a switch is still waiting replaces the waiting code. Only the latest code ever takes effect.
- R7: If no write is made, the code in effect and the pulse rate stay unchanged for any number of cycles.
- R8: A change of `ext_mode`, seen at a rising edge, clears the divider. `cpu_en` is low after that edge. Any waiting code takes effect at that edge. The next pulse comes one full period of the code in effect after the change.
- R9: The code table does not depend on `ext_mode`. With `ext_mode` held at 1, code 011 passes every master cycle through and code 000 divides by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for the speed code |
| wr_code | input | 3 | Speed code to be written |
| ext_mode | input | 1 | Clock source mode, 1 = external source |
| cpu_en | output | 1 | One-master-cycle CPU clock enable |
| code_now | output | 3 | Speed code currently in effect |

## Verification
`cpu_en` is registered. It rises on the edge that follows the counter reaching all ones in the low bits of the selected tap. `code_now` and the counter clear are updated at that same edge, and a write takes one edge to enter the waiting register before it can count. The bench drives inputs at falling edges and steps a reference model once for each rising edge, using the same inputs. It compares both outputs at the next falling edge, so each result is checked in exactly the cycle it is due. Random writes and mode changes are mixed with directed cases for every code, replacement of a waiting code, long idle stretches and restarts.

// File: rtl/cpu_rate_pkg.sv
`timescale 1ns/1ps
package cpu_rate_pkg;

    localparam int CODE_W    = 3;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef enum logic [0:0] {
        RS_RUN  = 1'b0,   // code in effect, no change waiting
        RS_PEND = 1'b1    // new code held until the period boundary
    } rate_state_e;

    // log2 of the divide ratio for each speed code (non-monotonic order)
    function automatic int code_shift(input logic [CODE_W-1:0] code);
        int sh;
        unique case (code)
            3'd0:    sh = 3;
            3'd1:    sh = 2;
            3'd2:    sh = 1;
            3'd3:    sh = 0;
            3'd4:    sh = 4;
            3'd5:    sh = 5;
            3'd6:    sh = 7;
            default: sh = 8;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/rate_counter.sv
`timescale 1ns/1ps
module rate_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rate_tap_mux.sv
`timescale 1ns/1ps
module rate_tap_mux
    import cpu_rate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CODE_W-1:0] code,
    output logic              boundary
);

    logic [NUM_CODES-1:0] tap;

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_tap
        localparam int SH = code_shift(CODE_W'(c));
        if (SH == 0) begin : g_pass
            assign tap[c] = 1'b1;
        end else begin : g_and
            assign tap[c] = &cnt[SH-1:0];
        end
    end

    // 8:1 selector indexed by the code in effect
    assign boundary = tap[code];

endmodule

// File: rtl/rate_switch_fsm.sv
`timescale 1ns/1ps
module rate_switch_fsm
    import cpu_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              restart,
    input  logic              boundary,
    output logic [CODE_W-1:0] act_code,
    output logic              take_now,
    output logic              in_run
);

    rate_state_e       st_q, st_d;
    logic [CODE_W-1:0] pend_q, pend_d, act_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= RS_RUN;
            pend_q   <= '0;
            act_code <= '0;
        end else begin
            st_q     <= st_d;
            pend_q   <= pend_d;
            act_code <= act_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        act_d  = act_code;
        unique case (st_q)
            RS_RUN: begin
                if (wr_en) begin
                    pend_d = wr_code;
                    st_d   = RS_PEND;
                end
            end
            RS_PEND: begin
                if (restart || boundary) begin
                    act_d = pend_q;
                    st_d  = RS_RUN;
                end
                if (wr_en) begin
                    pend_d = wr_code;
                    st_d   = RS_PEND;
                end
            end
            default: st_d = RS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        take_now = 1'b0;
        in_run   = 1'b0;
        unique case (st_q)
            RS_RUN:  in_run   = 1'b1;
            RS_PEND: take_now = restart || boundary;
            default: in_run   = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu_rate_gen.sv
`timescale 1ns/1ps
module cpu_rate_gen
    import cpu_rate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              ext_mode,
    output logic              cpu_en,
    output logic [CODE_W-1:0] code_now
);

    logic             ext_q;
    logic             restart_w;
    logic             take_w;
    logic             boundary_w;
    logic             fsm_in_run;
    logic [CNT_W-1:0] cnt_w;

    // source mode tracking: any change restarts the divider chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_mode;
        end
    end

    assign restart_w = ext_mode ^ ext_q;

    rate_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart_w | take_w),
        .cnt   (cnt_w)
    );

    rate_tap_mux #(.CNT_W(CNT_W)) u_mux (
        .cnt      (cnt_w),
        .code     (code_now),
        .boundary (boundary_w)
    );

    rate_switch_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_code  (wr_code),
        .restart  (restart_w),
        .boundary (boundary_w),
        .act_code (code_now),
        .take_now (take_w),
        .in_run   (fsm_in_run)
    );

    // resynchronising output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en <= 1'b0;
        end else begin
            cpu_en <= boundary_w & ~restart_w;
        end
    end

endmodule

// File: rtl/cpu_rate_chk.sv
`timescale 1ns/1ps
module cpu_rate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_en,
    input logic [2:0] code_now,
    input logic       in_run,
    input logic       restart,
    input logic       take_now
);

    // R3: single-cycle pulse except in pass-through code
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && code_now != 3'b011) |=> !cpu_en);

    // R7: with no change waiting the code in effect holds
    assert_run_holds_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_run |=> $stable(code_now));

    // R5: the code changes only with a switch pulse or a restart
    assert_code_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_now) |-> (cpu_en || $past(restart)));

    // R4: a boundary switch emits the closing pulse of the old rate
    assert_switch_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_now && !restart) |=> cpu_en);

    // R8: a restart suppresses the enable
    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !cpu_en);

endmodule

bind cpu_rate_gen cpu_rate_chk u_rate_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_en   (cpu_en),
    .code_now (code_now),
    .in_run   (fsm_in_run),
    .restart  (restart_w),
    .take_now (take_w)
);

// File: tb/tb_cpu_rate_gen.sv
`timescale 1ns/1ps
module tb_cpu_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_code = 3'd0;
    logic       ext_mode = 1'b0;
    logic       cpu_en;
    logic [2:0] code_now;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    int       m_cnt  = 0;
    bit       m_extq = 1'b0;
    bit       m_pv   = 1'b0;
    bit [2:0] m_pend = 3'd0;
    bit [2:0] e_code = 3'd0;
    bit       e_en   = 1'b0;

    always #2.5 clk = ~clk;

    cpu_rate_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_code  (wr_code),
        .ext_mode (ext_mode),
        .cpu_en   (cpu_en),
        .code_now (code_now)
    );

    function automatic int ratio(input bit [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 4;
            3'd2: return 2;
            3'd3: return 1;
            3'd4: return 16;
            3'd5: return 32;
            3'd6: return 128;
            default: return 256;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one master cycle: drive at falling edge, model the rising edge, compare at next falling edge
    task automatic cyc(input bit w, input bit [2:0] wc, input bit ex, input string tag);
        bit rs;
        bit bnd;
        int r;
        wr_en    = w;
        wr_code  = wc;
        ext_mode = ex;
        rs = (ex != m_extq);
        m_extq = ex;
        if (rs) begin
            m_cnt = 0;
            e_en  = 1'b0;
            if (m_pv) begin
                e_code = m_pend;
                m_pv   = 1'b0;
            end
        end else begin
            r    = ratio(e_code);
            bnd  = ((m_cnt % r) == r - 1);
            e_en = bnd;
            if (m_pv && bnd) begin
                e_code = m_pend;
                m_pv   = 1'b0;
                m_cnt  = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 256;
            end
        end
        if (w) begin
            m_pend = wc;
            m_pv   = 1'b1;
        end
        @(negedge clk);
        check(tag, "cpu_en", int'(cpu_en), int'(e_en));
        check("R5", "code_now", int'(code_now), int'(e_code));
    endtask

    task automatic idle(input int n, input bit ex, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, ex, tag);
    endtask

    initial begin
        int seed;
        bit ex;
        seed = $urandom(32'd4242);
        ex = 1'b0;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", "cpu_en in reset", int'(cpu_en), 0);
            check("R1", "code_now in reset", int'(code_now), 0);
        end
        rst_n = 1'b1;
        // R1: first pulse on the 8th edge
        idle(20, 1'b0, "R1");
        // R2: every code, several periods each
        for (int c = 0; c < 8; c++) begin
            cyc(1'b1, 3'(c), 1'b0, "R2");
            idle(3 * ratio(3'(c)) + 2, 1'b0, "R2");
        end
        // R3: pass-through code
        cyc(1'b1, 3'd3, 1'b0, "R3");
        idle(12, 1'b0, "R3");
        // R4: slow to fast and fast to slow
        cyc(1'b1, 3'd7, 1'b0, "R4");
        idle(100, 1'b0, "R4");
        cyc(1'b1, 3'd2, 1'b0, "R4");
        idle(200, 1'b0, "R4");
        // R6: replace a waiting code
        cyc(1'b1, 3'd6, 1'b0, "R6");
        idle(2, 1'b0, "R6");
        cyc(1'b1, 3'd1, 1'b0, "R6");
        idle(3, 1'b0, "R6");
        cyc(1'b1, 3'd5, 1'b0, "R6");
        idle(80, 1'b0, "R6");
        // R7: long idle, no write
        idle(600, 1'b0, "R7");
        // R8: restart with a code waiting
        cyc(1'b1, 3'd4, 1'b0, "R8");
        idle(2, 1'b0, "R8");
        idle(40, 1'b1, "R8");
        idle(5, 1'b0, "R8");
        idle(30, 1'b1, "R8");
        // R9: external mode, pass-through and divide by 8
        cyc(1'b1, 3'd3, 1'b1, "R9");
        idle(10, 1'b1, "R9");
        cyc(1'b1, 3'd0, 1'b1, "R9");
        idle(30, 1'b1, "R9");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit w;
            w = (($urandom % 24) == 0);
            if (($urandom % 300) == 0) ex = ~ex;
            cyc(w, 3'($urandom % 8), ex, "R4");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule